// File: doc/BRIEF.md
# Interprocessor Interrupt and Run Control Unit

This unit sits between the processors of a shared-memory multiprocessor and lets any one of them signal any group of the others. A source names its targets with a bit mask and either posts an interrupt at one of several priority levels, halts the targets, or lets them run again. A permission matrix decides, pair by pair, which source may act on which target. Software loads the matrix one source row at a time, and a bank of manual switches can force any single pair to allowed or forbidden regardless of what software wrote.

Each target keeps one pending bit per level and per source. It sees its most urgent pending request as a level and a source number, and it retires that one request with an acknowledge. A run flag per target reflects the most recent halt or resume command. A common time-base tick, one cycle wide and repeating every programmable number of cycles, is driven to all processors for their local interval timers.

Top module: `ipi_ctrl`

## Requirements
- R1: A source s whose `req_op` field (bits 2s+1:2s) is 01 (interrupt) sets, for every permitted target t with `req_tgt[s*NPROC+t]` high, the pending bit at the level in `req_lvl` (bits 2s+1:2s) and source s. `irq_pend[t]` is high from the clock edge that samples the request onward, while any bit of target t is pending.
- R2: For each target, `irq_lvl` (bits 2t+1:2t) shows the highest pending level (3 is most urgent) and `irq_src` (bits 3t+2:3t) shows the lowest-numbered source pending at that level. Both read 0 when nothing is pending.
- R3: `tgt_ack[t]` clears exactly the pending bit that target t reports in that cycle, and no other bit. A new request for the same bit in the same cycle keeps it set.
- R4: The permission for source s and target t is `sw_allow[s*NPROC+t]` when `sw_force[s*NPROC+t]` is high, and otherwise the program bit. The program matrix resets to all pairs allowed. When `pw_en` is high, row `pw_src` is replaced by `pw_row` (bit t is target t), and the new row takes effect from the next cycle.
- R5: A request (op 01, 10 or 11) to a target that is not permitted has no effect on that target only. `req_err[s]` is high in the cycle after any request from s that named at least one forbidden target, and is low otherwise.
- R6: Op 10 (stop) clears `cpu_run[t]` and op 11 (restart) sets it, for every permitted masked target, from the next edge onward. Op 00 does nothing.
- R7: When a stop and a restart reach the same target in the same cycle, the target stops.
- R8: `tb_tick` is high for one cycle in every N, where N is `tb_period`; a value of 0 or 1 gives a tick every cycle. After reset the first tick comes N-1 cycles after reset is released.
- R9: During and right after reset no interrupt is pending, every processor is running and no error flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_op | input | 2*NPROC | Per-source command: 00 none, 01 interrupt, 10 stop, 11 restart |
| req_lvl | input | LW*NPROC | Per-source interrupt level |
| req_tgt | input | NPROC*NPROC | Per-source target mask, bit s*NPROC+t |
| tgt_ack | input | NPROC | Per-target acknowledge of the reported interrupt |
| pw_en | input | 1 | Program write of one permission row |
| pw_src | input | SW | Source row being written |
| pw_row | input | NPROC | New permitted-target mask for that row |
| sw_force | input | NPROC*NPROC | Manual override enable per pair |
| sw_allow | input | NPROC*NPROC | Manual override value per pair |
| tb_period | input | TW | Time-base tick period in cycles |
| irq_pend | output | NPROC | Target has a pending interrupt |
| irq_lvl | output | LW*NPROC | Reported level per target |
| irq_src | output | SW*NPROC | Reported source per target |
| cpu_run | output | NPROC | Run flag per target |
| req_err | output | NPROC | Per-source flag for a forbidden target |
| tb_tick | output | 1 | Shared time-base tick |

## Verification
A corrupted pending bit shows up at the ports as soon as it becomes the most urgent request of its target: the reported level or source is wrong in that cycle, and an acknowledge then retires the wrong request, so the fault carries on through later reports. A wrong permission bit shows in the cycle after the next request that names the pair, either through a missing or extra pending bit or through a wrong `req_err`. A corrupted run flag is visible at once on `cpu_run`. A tick counter that is off by one shows at the next tick, because the spacing between ticks moves.

// File: rtl/ipi_pkg.sv
// Shared command encoding for the interprocessor interrupt and run control unit.
package ipi_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_INT   = 2'b01,
        OP_STOP  = 2'b10,
        OP_RUN   = 2'b11
    } ipi_op_e;
endpackage

// File: rtl/ipi_perm.sv
// Permission matrix. Holds one program row per source and merges in the
// per-pair manual override. Assumes pw_src < NPROC.
module ipi_perm #(
    parameter int NPROC = 8,
    parameter int SW    = $clog2(NPROC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SW-1:0]            wr_src,
    input  logic [NPROC-1:0]         wr_row,
    input  logic [NPROC*NPROC-1:0]   man_en,
    input  logic [NPROC*NPROC-1:0]   man_val,
    output logic [NPROC*NPROC-1:0]   eff
);
    logic [NPROC-1:0][NPROC-1:0] prog;

    // Program rows: reset to all-allowed, one row replaced per write.
    always_ff @(posedge clk) begin
        if (!rst_n) prog <= '1;
        else if (wr_en) prog[wr_src] <= wr_row;
    end

    // Manual switch wins over the program bit, pair by pair.
    always_comb begin
        for (int i = 0; i < NPROC*NPROC; i++)
            eff[i] = man_en[i] ? man_val[i] : prog[i / NPROC][i % NPROC];
    end

    // R4
    row_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> prog[$past(wr_src)] == $past(wr_row));
endmodule

// File: rtl/ipi_pend.sv
// Pending store for one target: one bit per level and per source.
// Reports the highest level, lowest source; acknowledge retires that bit.
module ipi_pend #(
    parameter int NPROC = 8,
    parameter int NLVL  = 4,
    parameter int SW    = $clog2(NPROC),
    parameter int LW    = $clog2(NLVL)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NLVL*NPROC-1:0]   set_vec,
    input  logic                    ack,
    output logic                    valid,
    output logic [LW-1:0]           lvl,
    output logic [SW-1:0]           src
);
    logic [NLVL-1:0][NPROC-1:0] pend, set_p, clr;

    assign set_p = set_vec;

    // Priority pick: last hit of an ascending level scan, then lowest source.
    always_comb begin
        valid = 1'b0;
        lvl   = '0;
        src   = '0;
        for (int l = 0; l < NLVL; l++)
            if (|pend[l]) begin
                valid = 1'b1;
                lvl   = LW'(l);
            end
        for (int s = NPROC-1; s >= 0; s--)
            if (pend[lvl][s]) src = SW'(s);
    end

    // Clear mask: only the reported bit, only on acknowledge.
    always_comb begin
        clr = '0;
        if (ack && valid) clr[lvl][src] = 1'b1;
    end

    // Pending update: new arrivals win over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= set_p | (pend & ~clr);
    end

    // R2
    pick_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> pend[lvl][src]);

    // R3
    ack_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ack && !set_p[lvl][src]) |=> !pend[$past(lvl)][$past(src)]);
endmodule

// File: rtl/ipi_runctl.sv
// Run flags for all targets. Stop beats restart in the same cycle.
module ipi_runctl #(
    parameter int NPROC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPROC-1:0]  stop_hit,
    input  logic [NPROC-1:0]  go_hit,
    output logic [NPROC-1:0]  run
);
    // Flag update: reset running, stop first, then restart.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= '1;
        else        run <= (run | go_hit) & ~stop_hit;
    end

    // R7
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_hit != '0) |=> (run & $past(stop_hit)) == '0);

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((go_hit & ~stop_hit) != '0) |=>
        (run & $past(go_hit & ~stop_hit)) == $past(go_hit & ~stop_hit));
endmodule

// File: rtl/ipi_tick.sv
// Shared time base: one-cycle tick every tb_period cycles (0 or 1: every cycle).
module ipi_tick #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] period,
    output logic          tick
);
    logic [TW-1:0] cnt, lim;

    // Last count value of one period.
    assign lim  = (period <= TW'(1)) ? '0 : period - TW'(1);
    assign tick = (cnt >= lim);

    // Cycle counter: wraps to zero on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + TW'(1);
    end

    // R8
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && period > TW'(1)) |=> (!tick || period <= TW'(1)));
endmodule

// File: rtl/ipi_ctrl.sv
// Interprocessor interrupt and run control top. Decodes per-source commands,
// gates them through the permission matrix, feeds one pending store per
// target, the run flags and the error flags, and drives the time-base tick.
// Assumes every source presents at most one command per cycle.
module ipi_ctrl
    import ipi_pkg::*;
#(
    parameter int NPROC = 8,
    parameter int NLVL  = 4,
    parameter int TW    = 16,
    localparam int SW   = $clog2(NPROC),
    localparam int LW   = $clog2(NLVL)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2*NPROC-1:0]      req_op,
    input  logic [LW*NPROC-1:0]     req_lvl,
    input  logic [NPROC*NPROC-1:0]  req_tgt,
    input  logic [NPROC-1:0]        tgt_ack,
    input  logic                    pw_en,
    input  logic [SW-1:0]           pw_src,
    input  logic [NPROC-1:0]        pw_row,
    input  logic [NPROC*NPROC-1:0]  sw_force,
    input  logic [NPROC*NPROC-1:0]  sw_allow,
    input  logic [TW-1:0]           tb_period,
    output logic [NPROC-1:0]        irq_pend,
    output logic [LW*NPROC-1:0]     irq_lvl,
    output logic [SW*NPROC-1:0]     irq_src,
    output logic [NPROC-1:0]        cpu_run,
    output logic [NPROC-1:0]        req_err,
    output logic                    tb_tick
);
    logic [NPROC*NPROC-1:0] perm_eff;
    logic [NPROC-1:0]       stop_hit, go_hit, req_busy;

    ipi_perm #(.NPROC(NPROC)) u_perm (
        .clk(clk), .rst_n(rst_n), .wr_en(pw_en), .wr_src(pw_src),
        .wr_row(pw_row), .man_en(sw_force), .man_val(sw_allow), .eff(perm_eff)
    );

    genvar t;
    generate
        for (t = 0; t < NPROC; t++) begin : g_tgt
            logic [NLVL*NPROC-1:0] set_v;

            // Interrupt arrivals for target t, by level and source.
            always_comb begin
                for (int l = 0; l < NLVL; l++)
                    for (int s = 0; s < NPROC; s++)
                        set_v[l*NPROC+s] = (req_op[2*s +: 2] == OP_INT)
                                        && (req_lvl[LW*s +: LW] == LW'(l))
                                        && req_tgt[s*NPROC+t]
                                        && perm_eff[s*NPROC+t];
            end

            ipi_pend #(.NPROC(NPROC), .NLVL(NLVL)) u_pend (
                .clk(clk), .rst_n(rst_n), .set_vec(set_v), .ack(tgt_ack[t]),
                .valid(irq_pend[t]), .lvl(irq_lvl[LW*t +: LW]),
                .src(irq_src[SW*t +: SW])
            );
        end
    endgenerate

    // Permitted stop and restart hits per target.
    always_comb begin
        stop_hit = '0;
        go_hit   = '0;
        for (int tt = 0; tt < NPROC; tt++)
            for (int s = 0; s < NPROC; s++)
                if (req_tgt[s*NPROC+tt] && perm_eff[s*NPROC+tt]) begin
                    if (req_op[2*s +: 2] == OP_STOP) stop_hit[tt] = 1'b1;
                    if (req_op[2*s +: 2] == OP_RUN)  go_hit[tt]   = 1'b1;
                end
    end

    ipi_runctl #(.NPROC(NPROC)) u_run (
        .clk(clk), .rst_n(rst_n), .stop_hit(stop_hit), .go_hit(go_hit),
        .run(cpu_run)
    );

    // Sources presenting any command this cycle.
    always_comb begin
        for (int s = 0; s < NPROC; s++)
            req_busy[s] = (req_op[2*s +: 2] != OP_NONE);
    end

    // Error flags: a command naming at least one forbidden target.
    always_ff @(posedge clk) begin
        if (!rst_n) req_err <= '0;
        else
            for (int s = 0; s < NPROC; s++)
                req_err[s] <= req_busy[s]
                           && |(req_tgt[s*NPROC +: NPROC] & ~perm_eff[s*NPROC +: NPROC]);
    end

    ipi_tick #(.TW(TW)) u_tick (
        .clk(clk), .rst_n(rst_n), .period(tb_period), .tick(tb_tick)
    );

    // R5
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_err & ~$past(req_busy)) == '0);
endmodule

// File: tb/ipi_ctrl_bench.sv
`timescale 1ns/1ps
module ipi_ctrl_bench;
    localparam int NP = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  req_op = '0;
    logic [15:0]  req_lvl = '0;
    logic [63:0]  req_tgt = '0;
    logic [7:0]   tgt_ack = '0;
    logic         pw_en = 1'b0;
    logic [2:0]   pw_src = '0;
    logic [7:0]   pw_row = '0;
    logic [63:0]  sw_force = '0;
    logic [63:0]  sw_allow = '0;
    logic [15:0]  tb_period = 16'd5;
    logic [7:0]   irq_pend;
    logic [15:0]  irq_lvl;
    logic [23:0]  irq_src;
    logic [7:0]   cpu_run;
    logic [7:0]   req_err;
    logic         tb_tick;

    int n_chk = 0;
    int n_bad = 0;

    // Reference state, built from the requirements.
    bit pm [8][8];
    bit pd [8][4][8];
    bit mr [8];
    bit me [8];
    int mc;

    always #2 clk = ~clk;

    ipi_ctrl u_ipi_ctrl (
        .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_lvl(req_lvl),
        .req_tgt(req_tgt), .tgt_ack(tgt_ack), .pw_en(pw_en), .pw_src(pw_src),
        .pw_row(pw_row), .sw_force(sw_force), .sw_allow(sw_allow),
        .tb_period(tb_period), .irq_pend(irq_pend), .irq_lvl(irq_lvl),
        .irq_src(irq_src), .cpu_run(cpu_run), .req_err(req_err), .tb_tick(tb_tick)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Highest level, lowest source of the reference pending store.
    task automatic msel(int t, output bit v, output int l, output int s);
        v = 0; l = 0; s = 0;
        for (int li = 3; li >= 0; li--)
            for (int si = 7; si >= 0; si--)
                if (!v || l == li)
                    if (pd[t][li][si]) begin v = 1; l = li; s = si; end
    endtask

    task automatic send(int s, int op, int lvl, logic [7:0] mask);
        req_op[2*s +: 2]  = 2'(op);
        req_lvl[2*s +: 2] = 2'(lvl);
        req_tgt[8*s +: 8] = mask;
    endtask

    // One clock: predict, step, compare, release the one-shot inputs.
    task automatic cycle();
        bit eff [8][8];
        bit npd [8][4][8];
        bit v; int l; int s;
        int lim; int nmc;
        logic [7:0] ep; logic [15:0] el; logic [23:0] es; logic [7:0] er;
        lim = (tb_period <= 1) ? 0 : int'(tb_period) - 1;
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                eff[a][b] = sw_force[8*a+b] ? sw_allow[8*a+b] : pm[a][b];
        npd = pd;
        for (int t = 0; t < 8; t++)
            if (tgt_ack[t]) begin
                msel(t, v, l, s);
                if (v) npd[t][l][s] = 0;
            end
        for (int a = 0; a < 8; a++) begin
            me[a] = 0;
            for (int t = 0; t < 8; t++)
                if (req_tgt[8*a+t]) begin
                    if (!eff[a][t] && req_op[2*a +: 2] != 0) me[a] = 1;
                    if (eff[a][t] && req_op[2*a +: 2] == 1)
                        npd[t][req_lvl[2*a +: 2]][a] = 1;
                end
        end
        for (int t = 0; t < 8; t++) begin
            bit st; bit go; st = 0; go = 0;
            for (int a = 0; a < 8; a++)
                if (req_tgt[8*a+t] && eff[a][t]) begin
                    if (req_op[2*a +: 2] == 2) st = 1;
                    if (req_op[2*a +: 2] == 3) go = 1;
                end
            if (st) mr[t] = 0; else if (go) mr[t] = 1;
        end
        if (pw_en) for (int t = 0; t < 8; t++) pm[pw_src][t] = pw_row[t];
        nmc = (mc >= lim) ? 0 : mc + 1;
        @(posedge clk);
        pd = npd; mc = nmc;
        #1;
        ep = '0; el = '0; es = '0; er = '0;
        for (int t = 0; t < 8; t++) begin
            msel(t, v, l, s);
            ep[t] = v; el[2*t +: 2] = 2'(l); es[3*t +: 3] = 3'(s);
        end
        chk("R1 pending", 32'(irq_pend), 32'(ep));
        chk("R2 level", 32'(irq_lvl), 32'(el));
        chk("R2 source", 32'(irq_src), 32'(es));
        for (int t = 0; t < 8; t++) er[t] = mr[t];
        chk("R6 run", 32'(cpu_run), 32'(er));
        for (int t = 0; t < 8; t++) er[t] = me[t];
        chk("R5 err", 32'(req_err), 32'(er));
        chk("R8 tick", 32'(tb_tick), 32'(mc >= lim));
        req_op = '0; req_lvl = '0; req_tgt = '0; tgt_ack = '0; pw_en = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        int ticks;
        void'($urandom(32'd77));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int a = 0; a < 8; a++) begin
            mr[a] = 1; me[a] = 0;
            for (int b = 0; b < 8; b++) begin
                pm[a][b] = 1;
                for (int l = 0; l < 4; l++) pd[a][l][b] = 0;
            end
        end
        mc = 0;
        // R9: reset state
        chk("R9 pending", 32'(irq_pend), 32'h0);
        chk("R9 run", 32'(cpu_run), 32'hff);
        chk("R9 err", 32'(req_err), 32'h0);
        chk("R8 tick after reset", 32'(tb_tick), 32'h0);

        // R1: one request, two targets
        send(2, 1, 1, 8'h12); cycle();
        chk("R1 mask", 32'(irq_pend), 32'h12);
        chk("R1 level t1", 32'(irq_lvl[3:2]), 32'd1);
        chk("R1 source t1", 32'(irq_src[5:3]), 32'd2);

        // R2: higher level wins, then lowest source at that level
        send(5, 1, 3, 8'h02); send(0, 1, 1, 8'h02); cycle();
        chk("R2 top level", 32'(irq_lvl[3:2]), 32'd3);
        chk("R2 top source", 32'(irq_src[5:3]), 32'd5);
        send(3, 1, 3, 8'h02); cycle();
        chk("R2 lowest source", 32'(irq_src[5:3]), 32'd3);

        // R3: acknowledges retire one bit at a time
        tgt_ack = 8'h02; cycle();
        chk("R3 next source", 32'(irq_src[5:3]), 32'd5);
        tgt_ack = 8'h02; cycle();
        chk("R3 level drop", 32'(irq_lvl[3:2]), 32'd1);
        chk("R3 lowest left", 32'(irq_src[5:3]), 32'd0);
        chk("R3 other target kept", 32'(irq_pend[4]), 32'd1);

        // R5: forbidden target dropped alone, sender flagged
        pw_en = 1'b1; pw_src = 3'd6; pw_row = 8'hFB; cycle();
        send(6, 1, 2, 8'h0C); cycle();
        chk("R5 allowed target", 32'(irq_pend[3]), 32'd1);
        chk("R5 forbidden target", 32'(irq_pend[2]), 32'd0);
        chk("R5 sender flag", 32'(req_err[6]), 32'd1);

        // R4: manual switch overrides the program bit
        sw_force[6*8+2] = 1'b1; sw_allow[6*8+2] = 1'b1;
        send(6, 1, 2, 8'h04); cycle();
        chk("R4 forced allow", 32'(irq_pend[2]), 32'd1);
        chk("R4 no flag", 32'(req_err[6]), 32'd0);
        sw_force[0] = 1'b1; sw_allow[0] = 1'b0;
        send(0, 2, 0, 8'h01); cycle();
        chk("R4 forced deny", 32'(cpu_run[0]), 32'd1);
        sw_force = '0; sw_allow = '0;

        // R7: stop and restart together resolve to stop; R6 restart alone
        send(1, 2, 0, 8'h20); send(2, 3, 0, 8'h20); cycle();
        chk("R7 stop wins", 32'(cpu_run[5]), 32'd0);
        send(2, 3, 0, 8'h20); cycle();
        chk("R6 restart", 32'(cpu_run[5]), 32'd1);

        // R8: period 7 gives 10 ticks in 70 cycles
        tb_period = 16'd7;
        ticks = 0;
        for (int i = 0; i < 70; i++) begin
            cycle();
            if (tb_tick) ticks++;
        end
        chk("R8 tick count", 32'(ticks), 32'd10);

        // Random traffic against the reference model
        for (int i = 0; i < 4000; i++) begin
            for (int a = 0; a < 8; a++)
                if ($urandom_range(3) == 0)
                    send(a, ($urandom_range(3) == 0) ? $urandom_range(3) : 1,
                         $urandom_range(3), 8'($urandom));
            tgt_ack = 8'($urandom) & 8'($urandom);
            if ($urandom_range(15) == 0) begin
                pw_en = 1'b1; pw_src = 3'($urandom); pw_row = 8'($urandom) | 8'($urandom);
            end
            if (i % 200 == 0) begin
                sw_force = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
                sw_allow = {$urandom, $urandom};
            end
            if (i % 300 == 0) tb_period = 16'($urandom_range(9));
            cycle();
        end
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule